// File: doc/BRIEF.md
# Sixteen-Times Oversampling Serial Receiver

This block turns an asynchronous serial line into bytes. It watches the line only on clock cycles where an oversample enable is high. That enable runs at sixteen times the bit rate and is generated outside the block. The raw line first passes through a two-stage synchronizer.

A high-to-low change on the line starts a frame. From that edge the block counts ticks. Every sample point sits at a fixed tick count from the edge: the start-bit check, each data bit, the optional parity bit and the stop bit. No separate per-bit counter restarts at each bit.

When the stop bit has been sampled, the block presents the byte and a one-clock valid strobe. With that strobe it also updates three error flags: parity, framing and overrun. The consumer acknowledges each byte with a read pulse. A byte that completes before the previous one was acknowledged is flagged as an overrun.

Top module: `serial_rx16`

## Requirements
- R1: After reset, `rx_valid`, `err_parity`, `err_frame` and `err_overrun` are 0.
- R2: A falling edge begins a frame only if the line is still low at tick 8 after the edge. If it is high at tick 8, the block drops back to idle and produces no byte.
- R3: The eight data bits are sampled at ticks 24, 40, ..., 136 after the edge. The first bit received becomes `rx_data[0]` and the last becomes `rx_data[7]`.
- R4: With `par_en`=0, the stop bit is sampled at tick 152 and `err_parity` is 0 for that byte.
- R5: With `par_en`=1, the parity bit is sampled at tick 152 and the stop bit at tick 168. `err_parity` is set when the parity bit differs from XOR(data) XOR `par_odd`, where `par_odd`=0 selects even parity and 1 selects odd parity.
- R6: `err_frame` is 1 exactly when the stop bit was sampled low.
- R7: `rx_valid` is high for exactly one clock per received frame. `rx_data` and the error flags change only on that clock and hold until the next byte.
- R8: `err_overrun` is set with a byte when an earlier byte was delivered and no `rd_take` pulse occurred between the two deliveries. It is also set when `rd_take` and the new strobe fall in the same clock.
- R9: The block rearms after the stop sample. The next frame is recognised on the next high-to-low transition seen on a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| os_tick | input | 1 | Oversample enable, 16 per bit time |
| rx_in | input | 1 | Raw asynchronous serial line, idle high |
| par_en | input | 1 | 1 = frame carries a parity bit (hold stable during a frame) |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rd_take | input | 1 | Consumer has taken the current byte |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-clock strobe for a new byte |
| err_parity | output | 1 | Parity mismatch on last byte |
| err_frame | output | 1 | Stop bit was low on last byte |
| err_overrun | output | 1 | Last byte arrived while the previous one was unread |

## Verification
On every cycle, the assertions check these properties:
- the strobe lasts only one clock;
- the data word never moves without a strobe;
- a strobe only follows a tick;
- a parity error cannot appear while parity is off;
- an overrun always had an unread byte behind it.

Some behaviours only the bench scenarios can show, because they depend on what was driven onto the line:
- the values of the recovered bytes;
- LSB-first ordering;
- parity under both polarities;
- framing errors on a low stop bit;
- rejection of a short glitch;
- rearming after an error.

// File: rtl/serial_rx16.sv
module serial_rx16 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       os_tick,
  input  logic       rx_in,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       rd_take,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  output logic       err_parity,
  output logic       err_frame,
  output logic       err_overrun
);
  localparam int OS      = 16;
  localparam int NBITS   = 8;
  localparam int CW      = 8;
  localparam int CHK_PT  = OS / 2;
  localparam int D0_PT   = OS + OS / 2;
  localparam int DL_PT   = D0_PT + (NBITS - 1) * OS;
  localparam int P_PT    = DL_PT + OS;
  localparam int S2_PT   = P_PT + OS;

  logic [1:0]    sync_q;
  logic          rx_s, rx_q, busy, full_q, par_q;
  logic [CW-1:0] cnt, c;
  logic [7:0]    sh;
  logic          data_pt, par_pt, stop_pt;

  assign rx_s    = sync_q[1];
  assign c       = cnt + 1'b1;
  assign data_pt = (c >= CW'(D0_PT)) && (c <= CW'(DL_PT)) && (c[3:0] == 4'(CHK_PT));
  assign par_pt  = par_en && (c == CW'(P_PT));
  assign stop_pt = c == (par_en ? CW'(S2_PT) : CW'(P_PT));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q      <= 2'b11;
      rx_q        <= 1'b1;
      busy        <= 1'b0;
      cnt         <= '0;
      sh          <= '0;
      par_q       <= 1'b0;
      full_q      <= 1'b0;
      rx_data     <= '0;
      rx_valid    <= 1'b0;
      err_parity  <= 1'b0;
      err_frame   <= 1'b0;
      err_overrun <= 1'b0;
    end else begin
      sync_q   <= {sync_q[0], rx_in};
      rx_valid <= 1'b0;
      if (rd_take) full_q <= 1'b0;
      if (os_tick) begin
        rx_q <= rx_s;
        if (!busy) begin
          if (rx_q && !rx_s) begin
            busy <= 1'b1;
            cnt  <= '0;
          end
        end else begin
          cnt <= c;
          if (c == CW'(CHK_PT) && rx_s) busy <= 1'b0;
          if (data_pt) sh <= {rx_s, sh[7:1]};
          if (par_pt) par_q <= rx_s;
          if (stop_pt) begin
            busy        <= 1'b0;
            rx_data     <= sh;
            rx_valid    <= 1'b1;
            err_parity  <= par_en && (par_q != (^sh ^ par_odd));
            err_frame   <= ~rx_s;
            err_overrun <= full_q;
            full_q      <= 1'b1;
          end
        end
      end
    end
  end
endmodule

module serial_rx16_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       os_tick,
  input logic       par_en,
  input logic       full_q,
  input logic [7:0] rx_data,
  input logic       rx_valid,
  input logic       err_parity,
  input logic       err_overrun
);
  AST_ONE_CLK_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R7
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_data) |-> rx_valid); // R7
  AST_STROBE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(os_tick)); // R3
  AST_NO_PARITY_ERR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !par_en |-> !err_parity); // R4
  AST_OVERRUN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && err_overrun |-> $past(full_q)); // R8
endmodule

bind serial_rx16 serial_rx16_chk u_chk (
  .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .par_en(par_en),
  .full_q(full_q), .rx_data(rx_data), .rx_valid(rx_valid),
  .err_parity(err_parity), .err_overrun(err_overrun));

// File: tb/test_serial_rx16.sv
module test_serial_rx16;
  logic clk = 0, rst_n = 0, os_tick = 0, rx_in = 1;
  logic par_en = 0, par_odd = 0, rd_take = 0;
  logic [7:0] rx_data;
  logic rx_valid, err_parity, err_frame, err_overrun;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int got_n;
  logic [7:0] got_d;
  logic got_p, got_f, got_o;

  serial_rx16 i_serial_rx16 (.*);

  always #2 clk = ~clk;

  initial forever begin
    @(negedge clk); cyc++;
    os_tick = (cyc % 4 == 0);
  end

  initial begin
    wait (cyc > 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: act=timeout exp=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  function automatic logic par_of(logic [7:0] d, logic odd);
    return ^d ^ odd;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic hold(logic v, int clocks);
    rx_in = v;
    for (int i = 0; i < clocks; i++) begin
      @(negedge clk);
      if (rx_valid) begin
        got_n++; got_d = rx_data;
        got_p = err_parity; got_f = err_frame; got_o = err_overrun;
      end
    end
  endtask

  task automatic frame(logic [7:0] d, logic stop_v, logic bad_par);
    got_n = 0;
    hold(0, 64);
    for (int b = 0; b < 8; b++) hold(d[b], 64);
    if (par_en) hold(par_of(d, par_odd) ^ bad_par, 64);
    hold(stop_v, 64);
    hold(1, 80);
  endtask

  task automatic take();
    @(negedge clk); rd_take = 1; @(negedge clk); rd_take = 0;
  endtask

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (6) @(negedge clk);
    chk("R1 valid", rx_valid, 0);
    chk("R1 flags", {err_parity, err_frame, err_overrun}, 0);
    rst_n = 1;
    hold(1, 100);

    par_en = 0;
    frame(8'h01, 1, 0); take();
    chk("R3 lsb first", got_d, 8'h01);
    chk("R7 one strobe", got_n, 1);
    chk("R4 no perr", got_p, 0);
    frame(8'h80, 1, 0); take();
    chk("R3 msb last", got_d, 8'h80);

    for (int k = 0; k < 30; k++) begin
      logic [7:0] d;
      logic bp;
      d = 8'($urandom);
      par_en = 1'($urandom);
      par_odd = 1'($urandom);
      bp = ($urandom % 4 == 0);
      frame(d, 1, bp); take();
      chk("R3 data", got_d, d);
      chk("R7 one strobe", got_n, 1);
      chk(par_en ? "R5 parity" : "R4 parity off", got_p, par_en & bp);
      chk("R6 stop ok", got_f, 0);
      chk("R8 no overrun", got_o, 0);
    end

    par_en = 1; par_odd = 1;
    frame(8'hA5, 1, 1); take();
    chk("R5 odd mismatch", got_p, 1);
    par_odd = 0;
    frame(8'hA5, 1, 0); take();
    chk("R5 even match", got_p, 0);

    par_en = 0;
    frame(8'h3C, 0, 0); take();
    chk("R6 framing", got_f, 1);
    chk("R6 data kept", got_d, 8'h3C);
    frame(8'hC3, 1, 0); take();
    chk("R9 rearm after ferr", got_d, 8'hC3);
    chk("R6 frame clear", got_f, 0);

    got_n = 0;
    hold(0, 16);
    hold(1, 300);
    chk("R2 false start", got_n, 0);
    frame(8'h5A, 1, 0); take();
    chk("R2 after glitch", got_d, 8'h5A);

    frame(8'h11, 1, 0);
    frame(8'h22, 1, 0);
    chk("R8 overrun", got_o, 1);
    chk("R8 data", got_d, 8'h22);
    take();
    frame(8'h33, 1, 0); take();
    chk("R8 cleared", got_o, 0);
    chk("R9 back to back", got_d, 8'h33);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule